// File: doc/BRIEF.md
# Double-Fault Watchdog Supervisor

This block watches a processor that proves it is alive by toggling a service line. Each change on that line, rising or falling, starts the timeout window again. If a window closes with no change on the line, the block drives a short active-low fault pulse. One clock later it pulls a level fault output low. The level output stays low until the processor toggles the line again, or until it is reactivated.

A shutdown latch samples the level fault output at the moment the fault pulse falls. On a first missed window the level is still high when it is sampled, so nothing is latched. A second missed window in a row finds the level already low, so the latch sets and the system reset output is held asserted. Only the reactivate input clears it.

The window length comes from one of two parameterised cycle counts, chosen at run time by a select input. The pulse width is a third parameter.

Top module: `wdog_dual_fault`

## Requirements
- R1: After reset, `fault_pulse_n_o` and `fault_level_n_o` are high and `sys_rst_o` is low.
- R2: Every change of `svc_i`, in either direction, restarts the window. A change applied before clock edge N is acted on at edge N+2, after a two-flop synchroniser, so with no further change the next fault pulse falls DEF_CYCLES edges later (or ALT_CYCLES edges later when `alt_sel_i` is 1).
- R3: With no service, fault pulses repeat with a period of DEF_CYCLES clocks when `alt_sel_i` is 0 and ALT_CYCLES clocks when it is 1.
- R4: Each fault pulse holds `fault_pulse_n_o` low for exactly PULSE_CYCLES clocks.
- R5: `fault_level_n_o` falls exactly one clock after `fault_pulse_n_o` falls, and never before it.
- R6: Once low, `fault_level_n_o` stays low, with further pulses each period, until a service change or a reactivate returns it high.
- R7: On each fall of `fault_pulse_n_o`, the latch samples the pre-fault level. A first fault leaves `sys_rst_o` low. A second consecutive fault sets `sys_rst_o` high, and it then stays high.
- R8: A service change between two faults makes the next fault count as a first fault again, so `sys_rst_o` stays low.
- R9: A one-clock high on `reactivate_i` clears `sys_rst_o`, raises both fault outputs and restarts the window from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Service line, asynchronous; any change restarts the window |
| alt_sel_i | input | 1 | 0 selects DEF_CYCLES, 1 selects ALT_CYCLES |
| reactivate_i | input | 1 | Synchronous clear of the shutdown latch and fault level |
| fault_pulse_n_o | output | 1 | Active-low pulse, PULSE_CYCLES wide, per missed window |
| fault_level_n_o | output | 1 | Active-low level fault, held until service resumes |
| sys_rst_o | output | 1 | High while the shutdown latch is set |

## Verification
Several kinds of internal fault show up at the ports:
- A miscounted window counter shifts the time of the next pulse fall. This is visible within one window.
- A wrong pulse counter changes the pulse width before the pulse ends.
- A level register updated in the wrong cycle lets the latch see the new level. The shutdown then arrives one fault too early, or never.
- A latch that is not sticky drops `sys_rst_o` on the following pulse.

The bench runs a behavioural model alongside the design and compares all three outputs at every clock. Every timing comparison therefore lands in the cycle where a fault would first appear.

// File: rtl/wdog_dual_fault.sv
module wdog_dual_fault #(
  parameter int DEF_CYCLES   = 200_000_000,
  parameter int ALT_CYCLES   = 50_000_000,
  parameter int PULSE_CYCLES = 125_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_i,
  input  logic alt_sel_i,
  input  logic reactivate_i,
  output logic fault_pulse_n_o,
  output logic fault_level_n_o,
  output logic sys_rst_o
);
  localparam int MAXC = (DEF_CYCLES > ALT_CYCLES) ? DEF_CYCLES : ALT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int PW   = $clog2(PULSE_CYCLES + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pcnt_q;
  logic          lvl_q, shut_q, tmo_d_q;

  wire          svc_edge = sync_q[1] ^ sync_q[2];
  wire [CW-1:0] lim_m1   = alt_sel_i ? CW'(ALT_CYCLES - 1) : CW'(DEF_CYCLES - 1);
  wire          timeout  = ~reactivate_i & ~svc_edge & (cnt_q >= lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      tmo_d_q <= 1'b0;
      lvl_q   <= 1'b1;
      shut_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[1:0], svc_i};
      tmo_d_q <= timeout;

      if (reactivate_i || svc_edge || timeout) cnt_q <= '0;
      else                                     cnt_q <= cnt_q + 1'b1;

      if (reactivate_i)     pcnt_q <= '0;
      else if (timeout)     pcnt_q <= PW'(PULSE_CYCLES);
      else if (pcnt_q != 0) pcnt_q <= pcnt_q - 1'b1;

      // The level drops one clock after the pulse, so the latch samples the old level.
      if (reactivate_i || svc_edge) lvl_q <= 1'b1;
      else if (tmo_d_q)             lvl_q <= 1'b0;

      if (reactivate_i)           shut_q <= 1'b0;
      else if (timeout && !lvl_q) shut_q <= 1'b1;
    end
  end

  assign fault_pulse_n_o = (pcnt_q == '0);
  assign fault_level_n_o = lvl_q;
  assign sys_rst_o       = shut_q;

  assert_level_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_level_n_o) |-> $past(!fault_pulse_n_o));

  assert_level_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_level_n_o) |-> $past(svc_edge || reactivate_i));

  assert_shut_on_second_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($fell(fault_pulse_n_o) && !fault_level_n_o));

  assert_shut_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> $past(reactivate_i));

  assert_reactivate_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reactivate_i |=> (!sys_rst_o && fault_level_n_o && fault_pulse_n_o));
endmodule

// File: tb/wdog_dual_fault_tb_top.sv
module wdog_dual_fault_tb_top;
  localparam int DEF = 40, ALT = 25, PWID = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, svc = 1'b0, alt = 1'b0, react = 1'b0;
  logic pn, ln, srst;
  int total = 0, bad = 0, cyc = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  int falls[$];
  logic prev_pn = 1'b1;

  wdog_dual_fault #(.DEF_CYCLES(DEF), .ALT_CYCLES(ALT), .PULSE_CYCLES(PWID)) dut_i (
    .clk(clk), .rst_n(rst_n), .svc_i(svc), .alt_sel_i(alt), .reactivate_i(react),
    .fault_pulse_n_o(pn), .fault_level_n_o(ln), .sys_rst_o(srst));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_pcnt, m_lvl, m_shut, m_tmod;
  bit hist[$];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pcnt = 0; m_lvl = 1; m_shut = 0; m_tmod = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      int lim, n_lvl, n_shut;
      bit sv_edge, to;
      lim     = alt ? ALT : DEF;
      sv_edge = hist[1] != hist[2];
      to      = !react && !sv_edge && (m_cnt >= lim - 1);
      n_lvl   = react ? 1 : sv_edge ? 1 : m_tmod ? 0 : m_lvl;
      n_shut  = react ? 0 : (to && m_lvl == 0) ? 1 : m_shut;
      m_pcnt  = react ? 0 : to ? PWID : (m_pcnt > 0 ? m_pcnt - 1 : 0);
      m_cnt   = (react || sv_edge || to) ? 0 : m_cnt + 1;
      m_tmod  = to;
      m_lvl   = n_lvl;
      m_shut  = n_shut;
      hist.push_front(svc);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (prev_pn && !pn) falls.push_back(cyc);
    prev_pn = pn;
    if (rst_n && cmp_en) begin
      chk("R4 pulse vs model", pn, m_pcnt == 0);
      chk("R5 level vs model", ln, m_lvl[0]);
      chk("R7 shutdown vs model", srst, m_shut[0]);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_fall();
    int k;
    k = falls.size();
    while (falls.size() == k) tick(1);
  endtask

  task automatic reactivate();
    @(negedge clk); react = 1'b1;
    @(negedge clk); react = 1'b0; #1;
  endtask

  initial begin
    int t0, lowc;
    tick(5);
    rst_n = 1'b1;
    chk("R1 pulse idle high", pn, 1'b1);
    chk("R1 level idle high", ln, 1'b1);
    chk("R1 shutdown low", srst, 1'b0);
    cmp_en = 1'b1;

    repeat (20) begin tick(DEF - 10); svc = ~svc; end
    chk_int("R2 no fault while serviced", falls.size(), 0);
    tick(1);
    t0 = cyc;

    wait_fall();
    chk_int("R2 window restarts from last change", falls[$], t0 + 2 + DEF);
    chk("R7 first fault no shutdown", srst, 1'b0);
    chk("R5 level still high at pulse fall", ln, 1'b1);
    tick(1);
    chk("R5 level low one clock later", ln, 1'b0);
    lowc = 1;
    while (!pn) begin tick(1); lowc++; end
    chk_int("R4 pulse width", lowc, PWID);

    wait_fall();
    chk("R7 second fault shuts down", srst, 1'b1);
    chk_int("R3 default period", falls[$] - falls[$-1], DEF);
    tick(3 * DEF);
    chk("R7 shutdown held", srst, 1'b1);
    chk("R6 level held low", ln, 1'b0);
    chk_int("R6 repeated pulses", falls.size(), 5);

    reactivate();
    chk("R9 shutdown cleared", srst, 1'b0);
    chk("R9 level restored", ln, 1'b1);
    chk("R9 pulse high", pn, 1'b1);
    t0 = cyc;
    wait_fall();
    chk_int("R9 window restarts at reactivate", falls[$], t0 + DEF);

    tick(PWID + 2);
    svc = ~svc;
    tick(5);
    chk("R6 service restores level", ln, 1'b1);
    wait_fall();
    chk("R8 fault after service is first again", srst, 1'b0);
    wait_fall();
    chk("R7 consecutive fault shuts down", srst, 1'b1);

    @(negedge clk); react = 1'b1; alt = 1'b1;
    @(negedge clk); react = 1'b0; #1;
    chk("R9 cleared again", srst, 1'b0);
    wait_fall();
    wait_fall();
    chk_int("R3 alternate period", falls[$] - falls[$-1], ALT);
    chk("R7 alternate mode shutdown", srst, 1'b1);

    tick(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule